// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This synchronous controller owns the row strobe, column strobe and write strobe of an asynchronous DRAM whenever the memory is being brought up or refreshed. Once reset is released it first holds every strobe inactive for a start-up delay. It then runs a fixed number of initialization refresh cycles on its own, with no grant needed. After that it reports itself ready and switches to a distributed refresh schedule, so that every row is refreshed once per refresh period.

In periodic operation an interval timer adds one refresh to a pending count. While that count is non-zero and the sequencer is idle, it raises a request to the access controller. A refresh cycle starts only in a cycle where the grant is also high, so a refresh never cuts into an access that is already open. A mode input chooses how each cycle is performed. In the column-before-row style the device counts rows internally. In the row-only style the sequencer presents its own row counter on the address bus and advances that counter after each cycle. Every minimum pulse width is a parameter counted in clock cycles.

The state machine has five states. POWERUP holds all strobes high. IDLE waits for work. CAS_LEAD holds the column strobe low ahead of the row strobe. RAS_LOW holds the row strobe low. PRECHARGE holds all strobes high. The transitions are as follows.
- POWERUP goes to IDLE when the start-up delay expires.
- IDLE goes to CAS_LEAD when a column-before-row cycle starts, and to RAS_LOW when a row-only cycle starts.
- CAS_LEAD goes to RAS_LOW when its lead time expires.
- RAS_LOW goes to PRECHARGE when the row pulse width expires.
- PRECHARGE goes back to IDLE when the precharge time expires.

Top module: `dram_refresh_seq`

## Requirements
- R1: After ready, with the grant held high, refresh cycles start exactly once every REF_INTERVAL clock cycles.
- R2: No strobe falls during the first STARTUP_CYC cycles after reset. Exactly INIT_CNT refresh cycles then run without any grant. Ready rises after the last of them and stays high until the next reset.
- R3: In a column-before-row cycle, cas_n is low for at least T_CSR cycles before ras_n falls and stays low for as long as ras_n is low. In every cycle, ras_n stays low for at least T_RAS cycles.
- R4: we_n is high whenever ras_n falls, so a refresh is never taken as test-mode entry.
- R5: Between two refresh cycles, ras_n stays high for at least T_RP cycles.
- R6: A row-only cycle (ras_only_mode = 1 when the cycle starts) keeps cas_n high and raises row_oe while ras_n is low. row_addr then carries the row counter, which starts at 0, advances by one after each row-only cycle and wraps from 2^ROW_W-1 to 0.
- R7: After ready, a refresh cycle starts only on a clock edge where ref_req and ref_gnt are both high. ref_req is high while refreshes are pending and stays high until the granted cycle has finished.
- R8: pend_count rises by one for each elapsed refresh interval and falls by one when a granted refresh cycle ends. It never exceeds MISS_LIMIT.
- R9: overflow goes high when an interval elapses while pend_count already equals MISS_LIMIT, and it stays high until reset.
- R10: During reset, ras_n, cas_n and we_n are high, and ready, ref_req, row_oe, overflow, pend_count and row_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_only_mode | input | 1 | 1 selects a row-only cycle, 0 selects a column-before-row cycle; sampled when a cycle starts |
| ref_gnt | input | 1 | Grant from the access controller |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| row_addr | output | ROW_W | Row counter for row-only refresh |
| row_oe | output | 1 | Address bus drive enable during a row-only pulse |
| ref_req | output | 1 | Refresh request to the access controller |
| ready | output | 1 | Initialization has finished |
| pend_count | output | $clog2(MISS_LIMIT+1) | Refreshes owed |
| overflow | output | 1 | Sticky missed-refresh flag |

## Verification
A long random phase toggles the grant and the mode at random on every cycle. This mixes both refresh styles with arbitrary grant delays and shows whether pulse widths, strobe ordering, write-strobe level and row stepping hold however the cycles interleave. A phase with the grant held high shows that the schedule runs at exactly one cycle per interval. A phase with the grant held low shows that pending refreshes accumulate to an exact count, that the strobes stay quiet and that the request stays raised. Extending that phase past the limit separates saturation from overflow. Resets at the start and the end pin down the idle values.

// File: rtl/drs_pkg.sv
package drs_pkg;
    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_CAS_LEAD,
        ST_RAS_LOW,
        ST_PRECHARGE
    } drs_state_e;
endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer #(
    parameter int unsigned PERIOD = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned TW = $clog2(PERIOD + 1);
    logic [TW-1:0] cnt;

    assign tick = en && (cnt == TW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/drs_row_counter.sv
module drs_row_counter #(
    parameter int unsigned W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] row
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step) begin
            row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/drs_pend_tracker.sv
module drs_pend_tracker #(
    parameter int unsigned LIMIT = 4,
    parameter int unsigned PW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          done,
    output logic [PW-1:0] count,
    output logic          overflow
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            unique case ({tick, done})
                2'b10: begin
                    if (count == PW'(LIMIT)) begin
                        overflow <= 1'b1;
                    end else begin
                        count <= count + 1'b1;
                    end
                end
                2'b01: begin
                    if (count != '0) begin
                        count <= count - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import drs_pkg::*;
#(
    parameter int unsigned STARTUP_CYC  = 40000,
    parameter int unsigned INIT_CNT     = 8,
    parameter int unsigned REF_INTERVAL = 3120,
    parameter int unsigned T_RAS        = 12,
    parameter int unsigned T_RP         = 8,
    parameter int unsigned T_CSR        = 2,
    parameter int unsigned MISS_LIMIT   = 4,
    parameter int unsigned ROW_W        = 11
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ras_only_mode,
    input  logic                               ref_gnt,
    output logic                               ras_n,
    output logic                               cas_n,
    output logic                               we_n,
    output logic [ROW_W-1:0]                   row_addr,
    output logic                               row_oe,
    output logic                               ref_req,
    output logic                               ready,
    output logic [$clog2(MISS_LIMIT+1)-1:0]    pend_count,
    output logic                               overflow
);
    localparam int unsigned PW     = $clog2(MISS_LIMIT + 1);
    localparam int unsigned MAX_AB = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int unsigned MAX_C  = (MAX_AB > T_CSR) ? MAX_AB : T_CSR;
    localparam int unsigned DWELL  = (STARTUP_CYC > MAX_C) ? STARTUP_CYC : MAX_C;
    localparam int unsigned CW     = $clog2(DWELL + 1);
    localparam int unsigned IW     = $clog2(INIT_CNT + 1);

    drs_state_e     state;
    logic [CW-1:0]  dwell;
    logic [IW-1:0]  init_done;
    logic           cyc_row_only;
    logic           start_cycle;
    logic           tick;
    logic           row_step;
    logic           ref_done;

    assign start_cycle = !ready || ((pend_count != '0) && ref_gnt);
    assign row_step    = (state == ST_RAS_LOW) && (dwell == '0) && cyc_row_only;
    assign ref_done    = (state == ST_PRECHARGE) && (dwell == '0) && ready;

    drs_interval_timer #(.PERIOD(REF_INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ready),
        .tick  (tick)
    );

    drs_row_counter #(.W(ROW_W)) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (row_step),
        .row   (row_addr)
    );

    drs_pend_tracker #(.LIMIT(MISS_LIMIT), .PW(PW)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .done     (ref_done),
        .count    (pend_count),
        .overflow (overflow)
    );

    // State register and transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_POWERUP;
            dwell        <= CW'(STARTUP_CYC - 1);
            init_done    <= '0;
            cyc_row_only <= 1'b0;
            ready        <= 1'b0;
        end else begin
            unique case (state)
                ST_POWERUP: begin
                    if (dwell == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        dwell <= dwell - 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (start_cycle) begin
                        cyc_row_only <= ras_only_mode;
                        if (ras_only_mode) begin
                            state <= ST_RAS_LOW;
                            dwell <= CW'(T_RAS - 1);
                        end else begin
                            state <= ST_CAS_LEAD;
                            dwell <= CW'(T_CSR - 1);
                        end
                    end
                end
                ST_CAS_LEAD: begin
                    if (dwell == '0) begin
                        state <= ST_RAS_LOW;
                        dwell <= CW'(T_RAS - 1);
                    end else begin
                        dwell <= dwell - 1'b1;
                    end
                end
                ST_RAS_LOW: begin
                    if (dwell == '0) begin
                        state <= ST_PRECHARGE;
                        dwell <= CW'(T_RP - 1);
                    end else begin
                        dwell <= dwell - 1'b1;
                    end
                end
                ST_PRECHARGE: begin
                    if (dwell == '0) begin
                        state <= ST_IDLE;
                        if (!ready) begin
                            init_done <= init_done + 1'b1;
                            if (init_done == IW'(INIT_CNT - 1)) begin
                                ready <= 1'b1;
                            end
                        end
                    end else begin
                        dwell <= dwell - 1'b1;
                    end
                end
                default: state <= ST_POWERUP;
            endcase
        end
    end

    // Strobe and handshake outputs
    always_comb begin
        ras_n   = 1'b1;
        cas_n   = 1'b1;
        we_n    = 1'b1;
        row_oe  = 1'b0;
        ref_req = 1'b0;
        unique case (state)
            ST_POWERUP: ;
            ST_IDLE: begin
                ref_req = ready && (pend_count != '0);
            end
            ST_CAS_LEAD: begin
                cas_n   = 1'b0;
                ref_req = ready;
            end
            ST_RAS_LOW: begin
                ras_n   = 1'b0;
                cas_n   = cyc_row_only;
                row_oe  = cyc_row_only;
                ref_req = ready;
            end
            ST_PRECHARGE: begin
                ref_req = ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
    parameter int unsigned STARTUP_CYC = 40000,
    parameter int unsigned T_RAS       = 12,
    parameter int unsigned T_RP        = 8,
    parameter int unsigned T_CSR       = 2,
    parameter int unsigned MISS_LIMIT  = 4,
    parameter int unsigned PW          = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic          row_oe,
    input logic          ready,
    input logic [PW-1:0] pend_count
);
    int unsigned cas_low_run;
    int unsigned ras_low_run;
    int unsigned ras_high_run;
    int unsigned up_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_low_run  <= 0;
            ras_low_run  <= 0;
            ras_high_run <= 0;
            up_cnt       <= 0;
        end else begin
            cas_low_run  <= cas_n ? 0 : ((cas_low_run < 65535) ? cas_low_run + 1 : cas_low_run);
            ras_low_run  <= ras_n ? 0 : ((ras_low_run < 65535) ? ras_low_run + 1 : ras_low_run);
            ras_high_run <= !ras_n ? 0 : ((ras_high_run < 65535) ? ras_high_run + 1 : ras_high_run);
            if (up_cnt < STARTUP_CYC) up_cnt <= up_cnt + 1;
        end
    end

    assert_startup_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt < STARTUP_CYC) |-> (ras_n && cas_n));
    assert_ready_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready) |-> ready);
    assert_cbr_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> (cas_low_run >= T_CSR));
    assert_ras_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_low_run >= T_RAS));
    assert_we_at_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> we_n);
    assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_high_run >= T_RP));
    assert_row_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_oe |-> (cas_n && !ras_n));
    assert_pend_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(pend_count) <= MISS_LIMIT));
endmodule

bind dram_refresh_seq drs_checker #(
    .STARTUP_CYC (STARTUP_CYC),
    .T_RAS       (T_RAS),
    .T_RP        (T_RP),
    .T_CSR       (T_CSR),
    .MISS_LIMIT  (MISS_LIMIT),
    .PW          ($clog2(MISS_LIMIT + 1))
) u_drs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .row_oe     (row_oe),
    .ready      (ready),
    .pend_count (pend_count)
);

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;
    localparam int unsigned STARTUP_CYC  = 50;
    localparam int unsigned INIT_CNT     = 8;
    localparam int unsigned REF_INTERVAL = 40;
    localparam int unsigned T_RAS        = 4;
    localparam int unsigned T_RP         = 3;
    localparam int unsigned T_CSR        = 2;
    localparam int unsigned MISS_LIMIT   = 3;
    localparam int unsigned ROW_W        = 5;
    localparam int unsigned PW           = $clog2(MISS_LIMIT + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_only_mode = 1'b0;
    logic ref_gnt = 1'b0;
    logic ras_n, cas_n, we_n, row_oe, ref_req, ready, overflow;
    logic [ROW_W-1:0] row_addr;
    logic [PW-1:0] pend_count;

    always #2.5 clk = ~clk;

    dram_refresh_seq #(
        .STARTUP_CYC(STARTUP_CYC), .INIT_CNT(INIT_CNT), .REF_INTERVAL(REF_INTERVAL),
        .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR), .MISS_LIMIT(MISS_LIMIT), .ROW_W(ROW_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ras_only_mode(ras_only_mode), .ref_gnt(ref_gnt),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr), .row_oe(row_oe),
        .ref_req(ref_req), .ready(ready), .pend_count(pend_count), .overflow(overflow)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int gmode = 0;        // 0 random, 1 always grant, 2 never grant
    bit count_win = 0;
    int win_falls = 0;
    int ro_count = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat_inc(input int v);
        return (v < 65535) ? v + 1 : v;
    endfunction

    // monitor state
    int since_rst, high_run, cas_low_run, ras_low_run, init_falls;
    int exp_row;
    bit prev_ras, prev_cas, prev_ready, seen_first, gflag, cyc_cbr, cas_broke;

    always @(negedge clk) begin
        if (!rst_n) begin
            since_rst = 0; high_run = 0; cas_low_run = 0; ras_low_run = 0;
            init_falls = 0; exp_row = 0; prev_ras = 1; prev_cas = 1; prev_ready = 0;
            seen_first = 0; gflag = 0; cyc_cbr = 0; cas_broke = 0;
        end else begin
            since_rst = since_rst + 1;
            if (!seen_first && (!ras_n || !cas_n)) begin
                seen_first = 1;
                check(since_rst > STARTUP_CYC, "R2 startup delay", since_rst, STARTUP_CYC + 1);
            end
            if (ready && ((prev_cas && !cas_n && ras_n) || (prev_ras && !ras_n && cas_n)))
                check(gflag, "R7 start without grant", 0, 1);
            if (prev_ras && !ras_n) begin
                check(high_run >= T_RP, "R5 precharge", high_run, T_RP);
                check(we_n, "R4 we_n at ras fall", we_n, 1);
                cyc_cbr = !cas_n;
                cas_broke = 0;
                if (!cas_n) begin
                    check(cas_low_run >= T_CSR, "R3 cas lead", cas_low_run, T_CSR);
                end else begin
                    check(row_oe && (int'(row_addr) == exp_row), "R6 row address", int'(row_addr), exp_row);
                    exp_row = (exp_row + 1) % (1 << ROW_W);
                    ro_count++;
                end
                if (!ready) init_falls++;
                if (count_win) win_falls++;
            end
            if (!ras_n && cyc_cbr && cas_n) cas_broke = 1;
            if (!prev_ras && ras_n) begin
                check(ras_low_run >= T_RAS, "R3 ras width", ras_low_run, T_RAS);
                check(!cas_broke, "R3 cas held low", cas_broke, 0);
                gflag = 0;
            end
            if (!prev_ready && ready)
                check(init_falls == INIT_CNT, "R2 init burst", init_falls, INIT_CNT);
            if (prev_ready && !ready)
                check(0, "R2 ready dropped", 0, 1);
            // drive inputs for the next edge
            case (gmode)
                1: ref_gnt = 1'b1;
                2: ref_gnt = 1'b0;
                default: ref_gnt = 1'($urandom % 2);
            endcase
            ras_only_mode = 1'($urandom % 2);
            if (ready && ref_req && ref_gnt) gflag = 1;
            high_run    = ras_n ? sat_inc(high_run) : 0;
            cas_low_run = cas_n ? 0 : sat_inc(cas_low_run);
            ras_low_run = ras_n ? 0 : sat_inc(ras_low_run);
            prev_ras = ras_n; prev_cas = cas_n; prev_ready = ready;
        end
    end

    task automatic check_reset_state();
        check(ras_n && cas_n && we_n, "R10 strobes high", {ras_n, cas_n, we_n}, 7);
        check(!ready && !ref_req && !row_oe && !overflow, "R10 flags low",
              {ready, ref_req, row_oe, overflow}, 0);
        check(pend_count == '0 && row_addr == '0, "R10 counters zero",
              int'(pend_count) + int'(row_addr), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        int guard;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        while (!ready) @(negedge clk);
        check(ready, "R2 ready reached", ready, 1);

        // random grants and modes
        repeat (6000) @(negedge clk);

        // spacing with grant held high
        @(posedge clk); gmode = 1;
        do @(negedge clk); while (pend_count != '0);
        win_falls = 0; count_win = 1;
        repeat (10 * REF_INTERVAL) @(negedge clk);
        count_win = 0;
        check(win_falls == 10, "R1 refresh spacing", win_falls, 10);

        // accumulation with grant withheld
        do @(negedge clk); while (pend_count != '0);
        @(posedge clk); gmode = 2;
        repeat (2 * REF_INTERVAL) @(negedge clk);
        check(int'(pend_count) == 2, "R8 pending count", int'(pend_count), 2);
        check(ref_req, "R7 request raised", ref_req, 1);
        check(!overflow, "R9 no early overflow", overflow, 0);
        repeat (2 * REF_INTERVAL) @(negedge clk);
        check(int'(pend_count) == MISS_LIMIT, "R8 saturation", int'(pend_count), MISS_LIMIT);
        check(overflow, "R9 overflow set", overflow, 1);

        // drain
        @(posedge clk); gmode = 1;
        guard = 0;
        do begin @(negedge clk); guard++; end while (pend_count != '0 && guard < 300);
        check(pend_count == '0, "R8 drain", int'(pend_count), 0);
        check(overflow, "R9 overflow sticky", overflow, 1);
        check(ro_count > (1 << ROW_W), "R6 row wrap exercised", ro_count, (1 << ROW_W) + 1);

        @(posedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end
endmodule